// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog timer that sits on a plain single-cycle register port. The system clock first goes through an 8-bit programmable prescaler and then through a second divider whose ratio is a selectable power of two. Each output pulse of that two-stage chain is one tick. Each tick lowers a 16-bit down-counter by one. When a tick finds the counter at zero, the counter reloads from a reload register. The same event can latch a sticky interrupt, start a fixed-length reset-request pulse, or do both, depending on two enable bits.

Software keeps the system alive by writing the live counter register before it reaches zero. It stops the watchdog by clearing the run and reset-enable bits. A pending interrupt is acknowledged through a dedicated write-only clear register. The register port has no handshake. A write takes effect on the clock edge where `bus_we` is high. Read data is a combinational function of `bus_addr`. It carries no stream traffic, so no valid/ready pair is used.

Top module: `prescaled_wdt`

## Requirements
- R1: The register index is `bus_addr[3:2]`: 0 is control, 1 is reload, 2 is live counter, 3 is interrupt clear. The control fields are: bit 0 reset enable, bit 2 interrupt enable, bits 4:3 divider select, bit 5 run, bits 15:8 prescaler value. All other control bits read 0. The reload and counter registers read in bits 15:0 with zeros above them. The clear register reads 0.
- R2: After reset, control reads 0x00008021 (prescaler 0x80, divide by 16, run on, reset enable on). Reload and counter both read 0x8000. `irq_o` and `rst_req_o` are low.
- R3: While run is set, one tick arrives every (prescaler+1)·(16 << divider select) clocks. The first tick after run is set arrives a full period after the enabling write.
- R4: Each tick lowers a non-zero counter by one. A write to the counter register loads it on that same edge and takes priority over a tick on that edge. A tick overridden this way causes no expiry.
- R5: A tick that finds the counter at 0 is an expiry. The counter reloads from the reload register, and `irq_o` goes high on that edge if interrupt enable is set. With interrupt enable clear, `irq_o` stays low.
- R6: `irq_o` stays high until a write of 1 in bit 0 to the clear register. A write with bit 0 equal to 0 leaves it set. An expiry on the same edge as a clear wins.
- R7: An expiry with reset enable set drives `rst_req_o` high for exactly RST_CYCLES clocks (128 by default), starting at the expiry edge.
- R8: While run is clear, the counter holds its value except for bus writes. No expiry happens, and the prescaler and divider are held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address; bits 3:2 pick the register |
| bus_we | input | 1 | Write strobe, one clock per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq_o | output | 1 | Sticky expiry interrupt |
| rst_req_o | output | 1 | System reset request pulse |

## Verification
The assertions check every cycle that:
- two ticks are never back to back;
- a tick lowers a non-zero counter by exactly one;
- a stopped counter moves only on a bus write;
- the interrupt stays set until cleared;
- each rise of the interrupt or the reset request follows an expiry with the matching enable.

Only the bench scenarios can show the following:
- the exact tick period across prescaler and divider settings;
- the reload value taken at expiry;
- the exact RST_CYCLES pulse length;
- the reset values and the masking of unused control bits.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 16;
  localparam int PSC_W  = 8;
  localparam int DSEL_W = 2;

  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_RELOAD = 2'd1,
    SEL_COUNT  = 2'd2,
    SEL_ICLR   = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [PSC_W-1:0]  psc;
    logic              run;
    logic [DSEL_W-1:0] dsel;
    logic              irq_en;
    logic              rst_en;
  } ctrl_t;
endpackage

// File: rtl/wdt_clkdiv.sv
module wdt_clkdiv #(
  parameter int PSC_W     = 8,
  parameter int DSEL_W    = 2,
  parameter int BASE_LOG2 = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [PSC_W-1:0]  psc,
  input  logic [DSEL_W-1:0] dsel,
  output logic              tick_o
);
  localparam int DCNT_W = BASE_LOG2 + (1 << DSEL_W) - 1;

  logic [PSC_W-1:0]  pcnt_q;
  logic [DCNT_W-1:0] dcnt_q;
  logic [DCNT_W:0]   span;
  logic [DCNT_W-1:0] dlim;
  logic              pre_hit;

  always_comb begin
    span    = (DCNT_W+1)'(1) << (BASE_LOG2 + int'(dsel));
    dlim    = DCNT_W'(span - (DCNT_W+1)'(1));
    pre_hit = (pcnt_q == psc);
    tick_o  = run && pre_hit && (dcnt_q == dlim);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
      dcnt_q <= '0;
    end else if (!run) begin
      pcnt_q <= '0;
      dcnt_q <= '0;
    end else begin
      pcnt_q <= pre_hit ? '0 : pcnt_q + PSC_W'(1);
      if (pre_hit) dcnt_q <= (dcnt_q == dlim) ? '0 : dcnt_q + DCNT_W'(1);
    end
  end

  // R3: the shortest tick period is 16 clocks, so ticks are never adjacent
  p_tick_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);
endmodule

// File: rtl/wdt_downcount.sv
module wdt_downcount #(
  parameter int          CNT_W   = 16,
  parameter logic [15:0] INIT_VAL = 16'h8000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  assign cnt_o    = cnt_q;
  assign expire_o = tick && !load_en && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= CNT_W'(INIT_VAL);
    else if (load_en)     cnt_q <= load_val;
    else if (tick)        cnt_q <= (cnt_q == '0) ? reload_val : cnt_q - CNT_W'(1);
  end

  p_decrement_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load_en && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
endmodule

// File: rtl/wdt_expiry.sv
module wdt_expiry #(
  parameter int RST_CYCLES = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic irq_en,
  input  logic rst_en,
  input  logic irq_clr,
  output logic irq_o,
  output logic rst_req_o
);
  localparam int RW = $clog2(RST_CYCLES + 1);

  logic [RW-1:0] rcnt_q;
  logic          irq_q;

  assign irq_o     = irq_q;
  assign rst_req_o = (rcnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (expire && rst_en)  rcnt_q <= RW'(RST_CYCLES);
      else if (rcnt_q != '0) rcnt_q <= rcnt_q - RW'(1);
      if (expire && irq_en)  irq_q <= 1'b1;
      else if (irq_clr)      irq_q <= 1'b0;
    end
  end

  p_irq_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !irq_clr) |=> irq_q);
  p_irq_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(expire && irq_en));
  p_rst_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req_o) |-> $past(expire && rst_en));
endmodule

// File: rtl/prescaled_wdt.sv
module prescaled_wdt
  import wdt_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int RST_CYCLES = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              rst_req_o
);
  localparam logic [CNT_W-1:0] INIT_COUNT = CNT_W'(16'h8000);
  localparam logic [PSC_W-1:0] INIT_PSC   = PSC_W'(8'h80);

  reg_sel_e         sel;
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] cnt;
  logic             tick;
  logic             expire;
  logic             wr_ctrl, wr_reload, wr_count, wr_clr;
  logic             unused_bits;

  assign sel       = reg_sel_e'(bus_addr[3:2]);
  assign wr_ctrl   = bus_we && (sel == SEL_CTRL);
  assign wr_reload = bus_we && (sel == SEL_RELOAD);
  assign wr_count  = bus_we && (sel == SEL_COUNT);
  assign wr_clr    = bus_we && (sel == SEL_ICLR) && bus_wdata[0];
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[DATA_W-1:16], bus_wdata[7:6], bus_wdata[1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '{psc: INIT_PSC, run: 1'b1, dsel: '0, irq_en: 1'b0, rst_en: 1'b1};
      reload_q <= INIT_COUNT;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.psc    <= bus_wdata[15:8];
        ctrl_q.run    <= bus_wdata[5];
        ctrl_q.dsel   <= bus_wdata[4:3];
        ctrl_q.irq_en <= bus_wdata[2];
        ctrl_q.rst_en <= bus_wdata[0];
      end
      if (wr_reload) reload_q <= bus_wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    unique case (sel)
      SEL_CTRL:   bus_rdata = {16'h0, ctrl_q.psc, 2'b00, ctrl_q.run, ctrl_q.dsel,
                               ctrl_q.irq_en, 1'b0, ctrl_q.rst_en};
      SEL_RELOAD: bus_rdata = {{(DATA_W-CNT_W){1'b0}}, reload_q};
      SEL_COUNT:  bus_rdata = {{(DATA_W-CNT_W){1'b0}}, cnt};
      default:    bus_rdata = '0;
    endcase
  end

  wdt_clkdiv #(.PSC_W(PSC_W), .DSEL_W(DSEL_W), .BASE_LOG2(4)) u_clkdiv (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q.run), .psc(ctrl_q.psc),
    .dsel(ctrl_q.dsel), .tick_o(tick)
  );

  wdt_downcount #(.CNT_W(CNT_W), .INIT_VAL(16'h8000)) u_count (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load_en(wr_count),
    .load_val(bus_wdata[CNT_W-1:0]), .reload_val(reload_q),
    .cnt_o(cnt), .expire_o(expire)
  );

  wdt_expiry #(.RST_CYCLES(RST_CYCLES)) u_expiry (
    .clk(clk), .rst_n(rst_n), .expire(expire), .irq_en(ctrl_q.irq_en),
    .rst_en(ctrl_q.rst_en), .irq_clr(wr_clr), .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  p_stop_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.run && !wr_count) |=> $stable(cnt));
  p_stop_no_expire_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.run |-> !expire);
endmodule

// File: tb/prescaled_wdt_tb.sv
`timescale 1ns/1ps
module prescaled_wdt_tb_top;
  localparam int RSTC = 128;
  localparam int NV   = 5;
  // {psc[7:0], dsel[1:0], count[15:0], expected clocks to interrupt[15:0]}
  localparam logic [41:0] VEC [NV] = '{
    {8'd0, 2'd0, 16'd2, 16'd48},
    {8'd1, 2'd1, 16'd1, 16'd128},
    {8'd2, 2'd3, 16'd0, 16'd384},
    {8'd0, 2'd2, 16'd3, 16'd256},
    {8'd3, 2'd0, 16'd4, 16'd320}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, rst_req_o;
  int          checks = 0, fails = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  prescaled_wdt #(.ADDR_W(4), .RST_CYCLES(RSTC)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 reset state
    rd(4'h0, v); check("R2 ctrl", v, 32'h0000_8021);
    rd(4'h4, v); check("R2 reload", v, 32'h8000);
    rd(4'h8, v); check("R2 count", v, 32'h8000);
    check("R2 irq", {31'b0, irq_o}, 0);
    check("R2 rst_req", {31'b0, rst_req_o}, 0);

    // R3 R5 tick period table
    for (int i = 0; i < NV; i++) begin
      wr(4'h0, 32'h0);
      wr(4'hC, 32'h1);
      wr(4'h4, 32'hFFFF);
      wr(4'h8, {16'h0, VEC[i][31:16]});
      wr(4'h0, {16'h0, VEC[i][41:34], 2'b00, 1'b1, VEC[i][33:32], 1'b1, 2'b00});
      n = 0;
      while (!irq_o && n < 2000) begin @(posedge clk); @(negedge clk); n++; end
      check("R3 period to expiry", n, {16'h0, VEC[i][15:0]});
    end
    wr(4'h0, 32'h0);
    wr(4'hC, 32'h1);

    // R1 control masking and clear register read
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, v); check("R1 ctrl mask", v, 32'h0000_FF3D);
    rd(4'hC, v); check("R1 clear reads zero", v, 0);
    wr(4'h0, 32'h0);

    // R4 decrement and immediate load
    wr(4'h8, 32'd10);
    wr(4'h0, 32'h20);
    cyc(15); rd(4'h8, v); check("R4 before first tick", v, 10);
    cyc(1);  rd(4'h8, v); check("R4 after first tick", v, 9);
    wr(4'h8, 32'h1234);
    rd(4'h8, v); check("R4 load while running", v, 32'h1234);
    wr(4'h0, 32'h0);

    // R5 reload at expiry
    wr(4'h4, 32'd5);
    wr(4'h8, 32'd0);
    wr(4'h0, 32'h24);
    cyc(15); check("R5 irq before expiry", {31'b0, irq_o}, 0);
    cyc(1);
    rd(4'h8, v); check("R5 reload value", v, 5);
    check("R5 irq at expiry", {31'b0, irq_o}, 1);
    wr(4'h0, 32'h0);

    // R6 clear register
    wr(4'hC, 32'h0); cyc(3);
    check("R6 clear with zero ignored", {31'b0, irq_o}, 1);
    wr(4'hC, 32'h1);
    check("R6 clear with one", {31'b0, irq_o}, 0);

    // R7 reset pulse length, irq disabled (R5)
    wr(4'h4, 32'd200);
    wr(4'h8, 32'd0);
    wr(4'h0, 32'h21);
    cyc(15); check("R7 no request before expiry", {31'b0, rst_req_o}, 0);
    cyc(1);  check("R7 request asserted", {31'b0, rst_req_o}, 1);
    check("R5 irq stays low when disabled", {31'b0, irq_o}, 0);
    cyc(RSTC - 1); check("R7 request still high", {31'b0, rst_req_o}, 1);
    cyc(1);        check("R7 request ended", {31'b0, rst_req_o}, 0);

    // R8 stopped counter holds, no expiry
    wr(4'h0, 32'h01);
    wr(4'h8, 32'd0);
    cyc(100);
    rd(4'h8, v); check("R8 count held", v, 0);
    check("R8 no reset request", {31'b0, rst_req_o}, 0);
    // R3 first tick after re-enable needs full period
    wr(4'h8, 32'd4);
    wr(4'h0, 32'h20);
    cyc(15); rd(4'h8, v); check("R3 full period after enable", v, 4);
    cyc(1);  rd(4'h8, v); check("R3 tick after enable", v, 3);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule